// File: doc/BRIEF.md
# Cache Access Sequencer

This block is the control state machine between a CPU, a unified cache, a translation unit and an external memory bus. In every cycle it looks at the CPU request and sorts it into one of four kinds. A cycle can be idle. It can be a fast sequential transfer that stays inside a line already known to be present. It can be a fully checked transfer, with the tag compare and the translation unit both active. Or it can be an access that has to leave the chip. The block then raises the enables for the tag compare and the translation unit, and the CPU wait, for that same cycle.

Accesses that leave the chip always spend one set-up cycle first. An uncacheable read or an unbuffered write then becomes a single bus transaction. A cacheable read miss fills the whole line from the bus, fetching the line words in ascending order. When the translation for that read is missing, a translation fetch runs before the fill. A translation fault aborts the access. The tag array, the data array, the translation unit and the bus are reached only through simple enable and acknowledge signals.

Top module: `cache_seq_ctrl`

## Requirements
- R1: After reset the block is in the checked state with no line known. The first access, even a sequential one with a nonzero word offset, raises `tag_en` and `mmu_en`.
- R2: A checked access with no fault completes with `cpu_wait` low in the same cycle. Such an access is either a read with `cpu_cacheable` and `tag_hit` high, or a write with `cpu_wbuf` high. During it `tag_en` and `mmu_en` are high.
- R3: Some accesses run on the fast path, with `tag_en`, `mmu_en` and `cpu_wait` all low. Each such access must meet all of these conditions:
  - `cpu_seq` is high.
  - `cpu_offset` is nonzero.
  - It is a read, or a write with `cpu_wbuf` high.
  - No idle cycle came between it and the previous access.
  - That previous access was a checked cacheable read hit, a completed line fill or a fast read. A fast buffered write keeps this state as it was.
- R4: A sequential access with `cpu_offset` equal to 0 has crossed into a new line. It always gets a full check.
- R5: Three kinds of unfaulted checked access raise `cpu_wait` in that cycle: a read miss, an uncacheable read and a write with `cpu_wbuf` low. The next cycle is a set-up cycle with `cpu_wait` high and `ext_req` low.
- R6: An uncacheable read or an unbuffered write becomes one bus transaction. During it `ext_req` is high, `ext_line` is low and `cpu_wait` is high until the cycle in which `bus_ack` is high. In that cycle the wait drops and the block returns to the checked state.
- R7: A cacheable read miss fills the line while `ext_line` and `cpu_wait` are high.
  - Each cycle with `bus_ack` high writes one word. In that cycle `fill_we` is high and `fill_idx` shows the word, starting at 0 and counting up to LINE_WORDS-1.
  - `cpu_wait` drops in the cycle of the last acknowledge.
  - A following sequential read with a nonzero offset takes the fast path.
- R8: When `mmu_xlat_hit` was low for a cacheable read miss, a translation fetch runs before the fill. During it `xlat_req`, `ext_req` and `cpu_wait` are high, and it ends in the cycle with `walk_ack` high.
- R9: On a checked access, `mmu_fault` pulses `abort` for that one cycle. It starts no bus activity and raises no wait. The next access gets a full check.
- R10: A cycle with `cpu_req` low, outside any bus activity, keeps `tag_en`, `mmu_en`, `cpu_wait` and `ext_req` low. It also ends any run of fast accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU makes a memory access this cycle |
| cpu_seq | input | 1 | Access follows the previous one in address order |
| cpu_we | input | 1 | Access is a write |
| cpu_wbuf | input | 1 | Write may go through the write buffer |
| cpu_cacheable | input | 1 | Address lies in cacheable memory |
| cpu_offset | input | clog2(LINE_WORDS) | Word index of the access within its line |
| tag_hit | input | 1 | Tag compare result for a checked access |
| mmu_xlat_hit | input | 1 | Translation unit already holds the mapping |
| mmu_fault | input | 1 | Translation unit rejects the access |
| walk_ack | input | 1 | Translation fetch finished |
| bus_ack | input | 1 | One bus word transferred |
| tag_en | output | 1 | Enable tag compare |
| mmu_en | output | 1 | Enable translation unit |
| ext_req | output | 1 | External bus activity in progress |
| xlat_req | output | 1 | Translation fetch in progress |
| ext_line | output | 1 | Line fill in progress |
| fill_we | output | 1 | Write the arriving word into the line |
| fill_idx | output | clog2(LINE_WORDS) | Word index of the arriving fill word |
| cpu_wait | output | 1 | Stall the CPU |
| abort | output | 1 | One-cycle abort of a faulted access |

## Verification
The bench sweeps every combination of these inputs, each from two prior states: one with a line known from a read hit, and one after an idle cycle.
- sequential flag
- write flag
- buffered-write flag
- cacheability
- tag hit
- translation presence
- fault
- word offset

The prior state tells the fast path apart from a full check. The offset sweep separates the wrap to word 0 from the offsets inside a line. The cacheability, tag-hit and write-type inputs decide between an in-cache completion, a single bus transaction and a line fill. Translation presence decides whether a translation fetch comes first. Every bus sequence is followed through to its end, with idle acknowledge cycles between the words. After each fill a sequential read confirms the fast path, and after each fault one confirms the full check. Directed runs cover the first access after reset and a chain of fast accesses that wraps and resumes.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FAST,
    ST_XSTART,
    ST_WALK,
    ST_FILL,
    ST_SINGLE
  } cc_state_e;

  typedef struct packed {
    logic check;
    logic fast;
    logic abort;
    logic ext;
    logic line;
    logic read_hit;
  } cc_class_t;

  // A request may skip tag and translation only inside a known line.
  function automatic logic fast_ok(input logic seq, input logic off_nz,
                                   input logic live, input logic we,
                                   input logic wbuf);
    return seq & off_nz & live & (~we | wbuf);
  endfunction

  // A checked access completes inside the cache path.
  function automatic logic stays_inside(input logic we, input logic wbuf,
                                        input logic cach, input logic hit);
    return we ? wbuf : (cach & hit);
  endfunction

endpackage

// File: rtl/cc_classify.sv
module cc_classify
  import cc_pkg::*;
(
  input  logic      req,
  input  logic      seq,
  input  logic      we,
  input  logic      wbuf,
  input  logic      cach,
  input  logic      hit,
  input  logic      fault,
  input  logic      off_nz,
  input  logic      live,
  output cc_class_t cls
);

  always_comb begin
    cls.fast     = req & fast_ok(seq, off_nz, live, we, wbuf);
    cls.check    = req & ~cls.fast;
    cls.abort    = cls.check & fault;
    cls.ext      = cls.check & ~fault & ~stays_inside(we, wbuf, cach, hit);
    cls.line     = ~we & cach;
    cls.read_hit = cls.check & ~fault & ~we & cach & hit;
  end

endmodule

// File: rtl/cc_fill_counter.sv
module cc_fill_counter #(
  parameter int WORDS = 4,
  localparam int W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] idx,
  output logic         at_last
);

  assign at_last = step && (idx == W'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) idx <= '0;
    else if (step)       idx <= idx + W'(1);
  end

endmodule

// File: rtl/cache_seq_ctrl.sv
module cache_seq_ctrl #(
  parameter int LINE_WORDS = 4,
  localparam int OFF_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_seq,
  input  logic             cpu_we,
  input  logic             cpu_wbuf,
  input  logic             cpu_cacheable,
  input  logic [OFF_W-1:0] cpu_offset,
  input  logic             tag_hit,
  input  logic             mmu_xlat_hit,
  input  logic             mmu_fault,
  input  logic             walk_ack,
  input  logic             bus_ack,
  output logic             tag_en,
  output logic             mmu_en,
  output logic             ext_req,
  output logic             xlat_req,
  output logic             ext_line,
  output logic             fill_we,
  output logic [OFF_W-1:0] fill_idx,
  output logic             cpu_wait,
  output logic             abort
);
  import cc_pkg::*;

  cc_state_e state_q, state_d;
  logic      live_q, live_d;
  logic      line_q, xlat_q;

  // Named internal events
  logic      path_ready;
  logic      off_nz;
  logic      fill_last;
  logic      fill_clear;
  cc_class_t cls;

  assign path_ready = (state_q == ST_IDLE) || (state_q == ST_CHECK) ||
                      (state_q == ST_FAST);
  assign off_nz     = |cpu_offset;
  assign fill_clear = (state_q == ST_XSTART);

  cc_classify u_classify (
    .req    (cpu_req & path_ready),
    .seq    (cpu_seq),
    .we     (cpu_we),
    .wbuf   (cpu_wbuf),
    .cach   (cpu_cacheable),
    .hit    (tag_hit),
    .fault  (mmu_fault),
    .off_nz (off_nz),
    .live   (live_q),
    .cls    (cls)
  );

  cc_fill_counter #(.WORDS(LINE_WORDS)) u_fill_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (fill_clear),
    .step    (fill_we),
    .idx     (fill_idx),
    .at_last (fill_last)
  );

  // Next state and known-line tracking
  always_comb begin
    state_d = state_q;
    live_d  = live_q;
    unique case (state_q)
      ST_IDLE, ST_CHECK, ST_FAST: begin
        if (!cpu_req) begin
          state_d = ST_IDLE;
          live_d  = 1'b0;
        end else if (cls.fast) begin
          state_d = ST_FAST;
        end else if (cls.ext) begin
          state_d = ST_XSTART;
          live_d  = 1'b0;
        end else begin
          state_d = ST_CHECK;
          live_d  = cls.read_hit;
        end
      end
      ST_XSTART: state_d = line_q ? (xlat_q ? ST_FILL : ST_WALK) : ST_SINGLE;
      ST_WALK:   if (walk_ack) state_d = ST_FILL;
      ST_FILL: begin
        if (fill_last) begin
          state_d = ST_CHECK;
          live_d  = 1'b1;
        end
      end
      ST_SINGLE: if (bus_ack) state_d = ST_CHECK;
      default:   state_d = ST_CHECK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_CHECK;
      live_q  <= 1'b0;
      line_q  <= 1'b0;
      xlat_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      live_q  <= live_d;
      if (cls.ext) begin
        line_q <= cls.line;
        xlat_q <= mmu_xlat_hit;
      end
    end
  end

  // Outputs
  assign tag_en   = cls.check;
  assign mmu_en   = cls.check;
  assign abort    = cls.abort;
  assign xlat_req = (state_q == ST_WALK);
  assign ext_line = (state_q == ST_FILL);
  assign ext_req  = xlat_req || ext_line || (state_q == ST_SINGLE);
  assign fill_we  = ext_line && bus_ack;
  assign cpu_wait = cls.ext || (state_q == ST_XSTART) || xlat_req ||
                    (ext_line && !fill_last) ||
                    ((state_q == ST_SINGLE) && !bus_ack);

  // Assertions
  assert_fast_skips_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && path_ready && !tag_en) |-> (!mmu_en && !cpu_wait && cpu_seq));

  assert_wrap_checks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && path_ready && cpu_offset == '0) |-> tag_en);

  assert_start_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cls.ext) |=> (cpu_wait && !ext_req));

  assert_bus_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_req || (ext_req && !bus_ack)) |-> cpu_wait);

  assert_fill_starts_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_line) |-> (fill_idx == '0));

  assert_abort_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);

  assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!cpu_wait && !ext_req));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_req && path_ready) |-> (!tag_en && !mmu_en && !cpu_wait && !ext_req));

endmodule

// File: tb/cache_seq_ctrl_bench.sv
module cache_seq_ctrl_bench;
  localparam int LW = 4;
  localparam int OW = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic cpu_req = 0, cpu_seq = 0, cpu_we = 0, cpu_wbuf = 0, cpu_cacheable = 0;
  logic [OW-1:0] cpu_offset = '0;
  logic tag_hit = 0, mmu_xlat_hit = 0, mmu_fault = 0, walk_ack = 0, bus_ack = 0;
  logic tag_en, mmu_en, ext_req, xlat_req, ext_line, fill_we, cpu_wait, abort;
  logic [OW-1:0] fill_idx;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cache_seq_ctrl #(.LINE_WORDS(LW)) u_cache_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_seq(cpu_seq),
    .cpu_we(cpu_we), .cpu_wbuf(cpu_wbuf), .cpu_cacheable(cpu_cacheable),
    .cpu_offset(cpu_offset), .tag_hit(tag_hit), .mmu_xlat_hit(mmu_xlat_hit),
    .mmu_fault(mmu_fault), .walk_ack(walk_ack), .bus_ack(bus_ack),
    .tag_en(tag_en), .mmu_en(mmu_en), .ext_req(ext_req), .xlat_req(xlat_req),
    .ext_line(ext_line), .fill_we(fill_we), .fill_idx(fill_idx),
    .cpu_wait(cpu_wait), .abort(abort)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic req, input logic seq, input logic we,
                       input logic wb, input logic cach, input logic hit,
                       input logic xh, input logic flt, input logic [OW-1:0] off);
    cpu_req = req; cpu_seq = seq; cpu_we = we; cpu_wbuf = wb;
    cpu_cacheable = cach; tag_hit = hit; mmu_xlat_hit = xh;
    mmu_fault = flt; cpu_offset = off;
  endtask

  // Non-sequential cacheable read hit at word 0: makes a line known
  task automatic prime_line();
    drive(1, 0, 0, 0, 1, 1, 1, 0, 0);
    cyc();
  endtask

  task automatic go_idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset tag_en", tag_en, 0);
    chk("R10 reset wait", cpu_wait, 0);
    chk("R10 reset ext_req", ext_req, 0);
    cyc();

    // R1: first access after reset, sequential with offset 1, gets a full check
    rst_n = 0;
    cyc();
    rst_n = 1;
    drive(1, 1, 0, 0, 1, 1, 1, 0, 1);
    #1;
    chk("R1 first seq access tag_en", tag_en, 1);
    chk("R1 first seq access mmu_en", mmu_en, 1);
    cyc();

    // R3/R4 chain: offsets 1, 2, 3 fast, then 0 checked, then 1 fast again
    go_idle();
    prime_line();
    for (int o = 1; o < LW; o++) begin
      drive(1, 1, 0, 0, 1, 0, 0, 0, OW'(o));
      #1;
      chk("R3 chain fast tag_en", tag_en, 0);
      chk("R3 chain fast wait", cpu_wait, 0);
      cyc();
    end
    drive(1, 1, 0, 0, 1, 1, 1, 0, 0);
    #1;
    chk("R4 wrap checked", tag_en, 1);
    cyc();
    drive(1, 1, 0, 0, 1, 0, 0, 0, 1);
    #1;
    chk("R3 fast after wrap hit", tag_en, 0);
    cyc();
    go_idle();
    drive(1, 1, 0, 0, 1, 1, 1, 0, 2);
    #1;
    chk("R10 idle ends fast run", tag_en, 1);
    cyc();
    go_idle();

    // Exhaustive sweep
    for (int i = 0; i < 1024; i++) begin
      logic [OW-1:0] off;
      logic live, seq, we, wb, cach, hit, xh, flt;
      logic e_fast, e_chk, e_abt, e_ext, e_line;
      off  = OW'(i & 3);
      live = i[2]; seq = i[3]; we = i[4]; wb = i[5];
      cach = i[6]; hit = i[7]; xh = i[8]; flt = i[9];

      if (live) prime_line();
      else go_idle();

      e_fast = seq && (off != 0) && live && (!we || wb);
      e_chk  = !e_fast;
      e_abt  = e_chk && flt;
      e_ext  = e_chk && !flt && !((we && wb) || (!we && cach && hit));
      e_line = !we && cach;

      drive(1, seq, we, wb, cach, hit, xh, flt, off);
      #1;
      if (e_fast) chk("R3 sweep tag_en", tag_en, 0);
      else if (off == 0 && seq) chk("R4 sweep tag_en", tag_en, 1);
      else chk("R2 sweep tag_en", tag_en, int'(e_chk));
      chk("R3 sweep mmu_en", mmu_en, int'(e_chk));
      chk("R9 sweep abort", abort, int'(e_abt));
      if (e_ext) chk("R5 sweep wait", cpu_wait, 1);
      else chk("R2 sweep wait", cpu_wait, 0);
      chk("R9 sweep ext_req", ext_req, 0);
      cyc();

      if (e_ext) begin
        #1;
        chk("R5 start wait", cpu_wait, 1);
        chk("R5 start ext_req", ext_req, 0);
        cyc();
        if (e_line) begin
          if (!xh) begin
            #1;
            chk("R8 walk xlat_req", xlat_req, 1);
            chk("R8 walk ext_req", ext_req, 1);
            chk("R8 walk wait", cpu_wait, 1);
            chk("R8 walk no fill", ext_line, 0);
            cyc();
            walk_ack = 1;
            #1;
            chk("R8 walk ack wait", cpu_wait, 1);
            cyc();
            walk_ack = 0;
          end
          for (int w = 0; w < LW; w++) begin
            bus_ack = 0;
            #1;
            chk("R7 fill ext_line", ext_line, 1);
            chk("R7 fill no ack we", fill_we, 0);
            chk("R7 fill wait", cpu_wait, 1);
            cyc();
            bus_ack = 1;
            #1;
            chk("R7 fill idx", fill_idx, w);
            chk("R7 fill we", fill_we, 1);
            chk("R7 fill wait at ack", cpu_wait, int'(w != LW - 1));
            cyc();
          end
          bus_ack = 0;
          drive(1, 1, 0, 0, 1, 0, 0, 0, 1);
          #1;
          chk("R7 fast after fill", tag_en, 0);
          chk("R7 fast after fill wait", cpu_wait, 0);
          cyc();
        end else begin
          bus_ack = 0;
          #1;
          chk("R6 single ext_req", ext_req, 1);
          chk("R6 single ext_line", ext_line, 0);
          chk("R6 single wait", cpu_wait, 1);
          cyc();
          bus_ack = 1;
          #1;
          chk("R6 single ack wait", cpu_wait, 0);
          chk("R6 single ack ext_req", ext_req, 1);
          cyc();
          bus_ack = 0;
          drive(1, 0, 0, 0, 1, 1, 1, 0, 2);
          #1;
          chk("R6 back to checked", tag_en, 1);
          chk("R6 back no wait", cpu_wait, 0);
          cyc();
        end
      end else if (e_abt) begin
        drive(1, 1, 0, 0, 1, 1, 1, 0, 2);
        #1;
        chk("R9 abort one cycle", abort, 0);
        chk("R9 checked after abort", tag_en, 1);
        cyc();
      end
      go_idle();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule